// File: doc/BRIEF.md
# Serial Transmitter with Synchronous Idle Fill

This block is the transmit half of a programmable serial port. A processor writes one character at a time into a single-entry holding register. From there the character moves into a shift register, which sends it out least-significant bit first on the serial line `txd`. Every bit boundary follows a falling edge of the external bit clock `txc`. The edge is detected inside the system clock domain through a two-stage synchronizer. Two status outputs tell software what it may do next: `txrdy` means a new character can be written, and `txe` means no data character is waiting or in flight.

In asynchronous operation each character is framed by a low start bit and a high stop period. An optional parity bit sits between the last data bit and the stop period, and the stop period can be one, one and a half or two bit times. The bit time is 1, 16 or 64 periods of `txc`. In synchronous operation each bit takes one `txc` period and no framing is added. When the holding register runs empty, the block keeps the line busy with one or two programmed synchronization characters until real data arrives.

Transmission is allowed only while the enable command bit is set and the active-low clear-to-send input is low. Dropping either one refuses further writes. A character already accepted, whether in the shifter or in the holding register, still goes out in full. A break command overrides everything and holds the line low. Mode and command decoding happen outside this block, which sees them as plain level inputs.

Top module: `serial_tx_fill`

## Requirements
- R1: While and after reset, with the enable bit clear, `txd` is 1, `txrdy` is 0 and `txe` is 1.
- R2: A write (`wr_en` high for one `clk` cycle) is accepted only when `tx_en` is 1, `cts_n` is 0 and the holding register is empty; `txrdy` is 1 exactly in that condition, so a write made while disabled never appears on `txd`.
- R3: A character accepted before `tx_en` falls or `cts_n` rises, whether it is in the shifter or still in the holding register, is transmitted in full.
- R4: An asynchronous frame (`sync_mode`=0) is a 0 start bit, then 8 data bits with the LSB first, an optional parity bit, and then a high stop period. One bit lasts F periods of `txc`, where `factor_sel` 2'b10 gives F=16, 2'b11 gives F=64, and 2'b00 or 2'b01 gives F=1.
- R5: With `parity_en`=1 a parity bit follows the data bits; it is the XOR of the 8 data bits when `parity_odd`=0 and its inverse when `parity_odd`=1.
- R6: The stop period lasts F `txc` periods for `stop_sel`=2'b00, F+F/2 for 2'b01 and 2F for 2'b10 or 2'b11; a character waiting in the holding register starts on the `txc` falling edge that ends the stop period.
- R7: `txd` changes only in response to a falling edge of `txc` or a change of `send_break`; with `txc` stopped, a written character is not sent until `txc` runs again.
- R8: In synchronous mode (`sync_mode`=1) each bit lasts one `txc` period and characters follow each other with no gap or framing. If the holding register is empty at a character boundary while transmission is enabled, a fill character is sent. Fill characters run `sync_a`, `sync_b`, `sync_a`, ... when `dual_sync`=1 and only `sync_a` when `dual_sync`=0, and the sequence restarts at `sync_a` after every data character.
- R9: `txe` is 0 from the cycle after a write is accepted until that character's last bit (and stop period) has been sent, and 1 otherwise, including while fill characters are being sent.
- R10: While `send_break` is 1, `txd` is 0 from the next `clk` cycle onward, regardless of any character in progress.
- R11: When no character is in progress and no break is requested, `txd` is 1 (mark); this includes synchronous mode after transmission is disabled.
- R12: A write made while the holding register is full is ignored; the waiting character is neither replaced nor duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | One-cycle strobe writing `wr_data` into the holding register |
| wr_data | input | 8 | Character to transmit |
| sync_mode | input | 1 | 1: synchronous mode, 0: asynchronous mode |
| factor_sel | input | 2 | Asynchronous bit-time factor (1, 16 or 64 `txc` periods) |
| parity_en | input | 1 | Append a parity bit |
| parity_odd | input | 1 | 1: odd parity, 0: even parity |
| stop_sel | input | 2 | Stop period: one, one and a half or two bit times |
| dual_sync | input | 1 | Alternate two fill characters instead of repeating one |
| sync_a | input | 8 | First fill character |
| sync_b | input | 8 | Second fill character |
| tx_en | input | 1 | Transmit-enable command bit |
| send_break | input | 1 | Break command: force the line low |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| txc | input | 1 | Bit clock; bits advance on its falling edge |
| txd | output | 1 | Serial data line |
| txrdy | output | 1 | Holding register can accept a character |
| txe | output | 1 | No data character waiting or being sent |

## Verification
The checker watches four things on every cycle: the line is low one cycle after a break request, the line is at mark whenever the shifter is idle and no break is requested, the line never moves without a `txc` falling edge or a break change in the right earlier cycles, and an accepted write drops both `txrdy` and `txe` at once. Things that depend on the content of a character can only be seen in the bench scenarios. These are the bit order, the parity value, the exact stop length measured between the starts of two back-to-back frames, the survival of a character written just before a disable, the discarding of writes made while disabled or while full, and the order of sync fill around a data character.

// File: rtl/serial_tx_fill_pkg.sv
package serial_tx_fill_pkg;

  typedef enum logic [1:0] {
    SH_IDLE = 2'b00,
    SH_BITS = 2'b01,
    SH_STOP = 2'b10
  } sh_state_e;

  localparam logic [1:0] FSEL_X16 = 2'b10;
  localparam logic [1:0] FSEL_X64 = 2'b11;

  localparam logic [1:0] STOP_SINGLE = 2'b00;
  localparam logic [1:0] STOP_ONE_HALF = 2'b01;

endpackage

// File: rtl/serial_tx_fill_sync.sv
module serial_tx_fill_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stg_d = d;
    end else begin : g_chain
      always_comb stg_d = {stg_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/serial_tx_fill_edge.sv
module serial_tx_fill_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txc,
  output logic tick
);

  logic txc_s;
  logic prev_q;
  logic prev_d;

  serial_tx_fill_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_txc_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (txc),
    .q    (txc_s)
  );

  always_comb prev_d = txc_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign tick = prev_q & ~txc_s;

endmodule

// File: rtl/serial_tx_fill_holdbuf.sv
module serial_tx_fill_holdbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    if (take) full_d = 1'b0;
    if (load) begin
      full_d = 1'b1;
      data_d = load_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      if (load) data_q <= data_d;
    end
  end

  assign full = full_q;
  assign data = data_q;

endmodule

// File: rtl/serial_tx_fill_shifter.sv
module serial_tx_fill_shifter
  import serial_tx_fill_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FACTOR_MID = 16,
  parameter int FACTOR_HI  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              sync_mode,
  input  logic [1:0]        factor_sel,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic [1:0]        stop_sel,
  input  logic              dual_sync,
  input  logic [DATA_W-1:0] sync_a,
  input  logic [DATA_W-1:0] sync_b,
  input  logic              buf_full,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              fill_ok,
  output logic              take,
  output logic              ser_out,
  output logic              data_busy,
  output logic              idle
);

  localparam int FRAME_W = DATA_W + 2;
  localparam int LEFT_W  = $clog2(FRAME_W + 1);
  localparam int TICK_W  = $clog2(2 * FACTOR_HI + 1);

  sh_state_e          st_q, st_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [LEFT_W-1:0]  left_q, left_d;
  logic [TICK_W-1:0]  sub_q, sub_d;
  logic               is_data_q, is_data_d;
  logic               sel_b_q, sel_b_d;

  logic [TICK_W-1:0]  factor;
  logic [TICK_W-1:0]  bit_ticks;
  logic [TICK_W-1:0]  stop_ticks;
  logic [DATA_W-1:0]  char_sel;
  logic               par_bit;
  logic [FRAME_W-1:0] load_sh;
  logic [LEFT_W-1:0]  load_left;
  logic               start_next;

  always_comb begin
    case (factor_sel)
      FSEL_X16: factor = TICK_W'(FACTOR_MID);
      FSEL_X64: factor = TICK_W'(FACTOR_HI);
      default:  factor = TICK_W'(1);
    endcase
    bit_ticks = sync_mode ? TICK_W'(1) : factor;
    case (stop_sel)
      STOP_SINGLE:   stop_ticks = factor;
      STOP_ONE_HALF: stop_ticks = factor + (factor >> 1);
      default:       stop_ticks = factor << 1;
    endcase
  end

  always_comb begin
    if (buf_full)     char_sel = buf_data;
    else if (sel_b_q) char_sel = sync_b;
    else              char_sel = sync_a;
    par_bit = (^char_sel) ^ parity_odd;
    if (sync_mode) begin
      load_sh   = {1'b0, par_bit, char_sel};
      load_left = LEFT_W'(DATA_W) + LEFT_W'(parity_en);
    end else begin
      load_sh   = {par_bit, char_sel, 1'b0};
      load_left = LEFT_W'(DATA_W + 1) + LEFT_W'(parity_en);
    end
  end

  always_comb begin
    st_d       = st_q;
    sh_d       = sh_q;
    left_d     = left_q;
    sub_d      = sub_q;
    is_data_d  = is_data_q;
    sel_b_d    = sel_b_q;
    take       = 1'b0;
    start_next = 1'b0;
    if (tick) begin
      case (st_q)
        SH_IDLE: start_next = 1'b1;
        SH_BITS: begin
          if (sub_q > TICK_W'(1)) begin
            sub_d = sub_q - TICK_W'(1);
          end else begin
            sh_d   = sh_q >> 1;
            left_d = left_q - LEFT_W'(1);
            sub_d  = bit_ticks;
            if (left_q == LEFT_W'(1)) begin
              if (sync_mode) begin
                start_next = 1'b1;
              end else begin
                st_d  = SH_STOP;
                sub_d = stop_ticks;
              end
            end
          end
        end
        SH_STOP: begin
          if (sub_q > TICK_W'(1)) sub_d = sub_q - TICK_W'(1);
          else                    start_next = 1'b1;
        end
        default: st_d = SH_IDLE;
      endcase
      if (start_next) begin
        if (buf_full) begin
          take      = 1'b1;
          st_d      = SH_BITS;
          sh_d      = load_sh;
          left_d    = load_left;
          sub_d     = bit_ticks;
          is_data_d = 1'b1;
          sel_b_d   = 1'b0;
        end else if (sync_mode && fill_ok) begin
          st_d      = SH_BITS;
          sh_d      = load_sh;
          left_d    = load_left;
          sub_d     = bit_ticks;
          is_data_d = 1'b0;
          sel_b_d   = dual_sync ? ~sel_b_q : 1'b0;
        end else begin
          st_d      = SH_IDLE;
          is_data_d = 1'b0;
          sel_b_d   = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SH_IDLE;
      sh_q      <= '0;
      left_q    <= '0;
      sub_q     <= '0;
      is_data_q <= 1'b0;
      sel_b_q   <= 1'b0;
    end else if (tick) begin
      st_q      <= st_d;
      sh_q      <= sh_d;
      left_q    <= left_d;
      sub_q     <= sub_d;
      is_data_q <= is_data_d;
      sel_b_q   <= sel_b_d;
    end
  end

  assign ser_out   = (st_q == SH_BITS) ? sh_q[0] : 1'b1;
  assign data_busy = (st_q != SH_IDLE) && is_data_q;
  assign idle      = (st_q == SH_IDLE);

endmodule

// File: rtl/serial_tx_fill.sv
module serial_tx_fill #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FACTOR_MID  = 16,
  parameter int FACTOR_HI   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sync_mode,
  input  logic [1:0]        factor_sel,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic [1:0]        stop_sel,
  input  logic              dual_sync,
  input  logic [DATA_W-1:0] sync_a,
  input  logic [DATA_W-1:0] sync_b,
  input  logic              tx_en,
  input  logic              send_break,
  input  logic              cts_n,
  input  logic              txc,
  output logic              txd,
  output logic              txrdy,
  output logic              txe
);

  logic              rst_int_n;
  logic              cts_s;
  logic              tick;
  logic              enable;
  logic              wr_ok;
  logic              buf_full;
  logic [DATA_W-1:0] buf_data;
  logic              take;
  logic              ser_out;
  logic              data_busy;
  logic              sh_idle;
  logic              txd_q, txd_d;

  serial_tx_fill_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (1'b1),
    .q    (rst_int_n)
  );

  serial_tx_fill_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d    (cts_n),
    .q    (cts_s)
  );

  serial_tx_fill_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk  (clk),
    .rst_n(rst_int_n),
    .txc  (txc),
    .tick (tick)
  );

  always_comb begin
    enable = tx_en & ~cts_s;
    wr_ok  = wr_en & enable & ~buf_full;
  end

  serial_tx_fill_holdbuf #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (wr_ok),
    .load_data(wr_data),
    .take     (take),
    .full     (buf_full),
    .data     (buf_data)
  );

  serial_tx_fill_shifter #(
    .DATA_W    (DATA_W),
    .FACTOR_MID(FACTOR_MID),
    .FACTOR_HI (FACTOR_HI)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick      (tick),
    .sync_mode (sync_mode),
    .factor_sel(factor_sel),
    .parity_en (parity_en),
    .parity_odd(parity_odd),
    .stop_sel  (stop_sel),
    .dual_sync (dual_sync),
    .sync_a    (sync_a),
    .sync_b    (sync_b),
    .buf_full  (buf_full),
    .buf_data  (buf_data),
    .fill_ok   (enable),
    .take      (take),
    .ser_out   (ser_out),
    .data_busy (data_busy),
    .idle      (sh_idle)
  );

  always_comb txd_d = send_break ? 1'b0 : ser_out;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) txd_q <= 1'b1;
    else            txd_q <= txd_d;
  end

  assign txd   = txd_q;
  assign txrdy = enable & ~buf_full;
  assign txe   = ~buf_full & ~data_busy;

endmodule

// File: rtl/serial_tx_fill_chk.sv
module serial_tx_fill_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic sh_idle,
  input logic buf_full,
  input logic wr_en,
  input logic send_break,
  input logic txd,
  input logic txrdy,
  input logic txe
);

  logic [1:0] warm_q, warm_d;
  logic       warm;

  always_comb warm_d = (warm_q == 2'd3) ? warm_q : warm_q + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= 2'd0;
    else        warm_q <= warm_d;
  end

  assign warm = (warm_q == 2'd3);

  // R10
  break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_break |=> !txd);

  // R11
  mark_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(sh_idle) && !$past(send_break)) |-> txd);

  // R7
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$past(tick, 2) && ($past(send_break) == $past(send_break, 2)))
      |-> (txd == $past(txd)));

  // R9
  empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !txe);

  // R2
  accept_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && txrdy) |=> (!txrdy && !txe));

endmodule

bind serial_tx_fill serial_tx_fill_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .tick      (tick),
  .sh_idle   (sh_idle),
  .buf_full  (buf_full),
  .wr_en     (wr_en),
  .send_break(send_break),
  .txd       (txd),
  .txrdy     (txrdy),
  .txe       (txe)
);

// File: tb/serial_tx_fill_test.sv
`timescale 1ns/1ps
module serial_tx_fill_test;

  localparam int TXC_HALF = 8;
  localparam int TXC_P    = 2 * TXC_HALF;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       sync_mode;
  logic [1:0] factor_sel;
  logic       parity_en;
  logic       parity_odd;
  logic [1:0] stop_sel;
  logic       dual_sync;
  logic [7:0] sync_a;
  logic [7:0] sync_b;
  logic       tx_en;
  logic       send_break;
  logic       cts_n;
  logic       txc;
  logic       txd;
  logic       txrdy;
  logic       txe;

  int n_checks = 0;
  int n_err    = 0;
  int cyc      = 0;
  bit txc_run  = 1'b1;
  bit mon_async = 1'b0;
  bit mon_sync  = 1'b0;
  logic [7:0] exp_q[$];
  int         starts[$];
  logic       sbits[$];

  serial_tx_fill uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .sync_mode(sync_mode), .factor_sel(factor_sel), .parity_en(parity_en),
    .parity_odd(parity_odd), .stop_sel(stop_sel), .dual_sync(dual_sync),
    .sync_a(sync_a), .sync_b(sync_b), .tx_en(tx_en), .send_break(send_break),
    .cts_n(cts_n), .txc(txc), .txd(txd), .txrdy(txrdy), .txe(txe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) cyc <= cyc + 1;

  initial txc = 1'b0;
  always begin
    repeat (TXC_HALF) @(negedge clk);
    if (txc_run) txc = ~txc;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int factor_now();
    case (factor_sel)
      2'b10:   return 16;
      2'b11:   return 64;
      default: return 1;
    endcase
  endfunction

  // Scoreboard monitor for asynchronous frames
  always begin
    @(negedge txd);
    if (mon_async) begin
      int bitc;
      logic [7:0] d;
      logic p, st0, stp;
      logic [7:0] e;
      starts.push_back(cyc);
      bitc = factor_now() * TXC_P;
      repeat (bitc / 2) @(negedge clk);
      st0 = txd;
      for (int i = 0; i < 8; i++) begin
        repeat (bitc) @(negedge clk);
        d[i] = txd;
      end
      p = 1'b0;
      if (parity_en) begin
        repeat (bitc) @(negedge clk);
        p = txd;
      end
      repeat (bitc) @(negedge clk);
      stp = txd;
      check(st0 == 1'b0, "R4", "start bit", st0, 0);
      check(stp == 1'b1, "R4", "stop level", stp, 1);
      if (parity_en)
        check(p == ((^d) ^ parity_odd), "R5", "parity bit", p, (^d) ^ parity_odd);
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected frame", d, 0);
      end else begin
        e = exp_q.pop_front();
        check(d == e, "R4", "frame data", d, e);
      end
    end
  end

  // Bit collector for synchronous mode
  always begin
    @(negedge txc);
    if (mon_sync) begin
      repeat (12) @(negedge clk);
      sbits.push_back(txd);
    end
  end

  function automatic bit has_seq(input logic [7:0] c0, input logic [7:0] c1,
                                 input logic [7:0] c2);
    logic [23:0] pat;
    pat = {c2, c1, c0};
    for (int i = 0; i + 24 <= sbits.size(); i++) begin
      bit ok = 1'b1;
      for (int j = 0; j < 24; j++)
        if (sbits[i + j] !== pat[j]) ok = 1'b0;
      if (ok) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic put(input logic [7:0] b, input bit expect_it);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = b;
    if (expect_it) exp_q.push_back(b);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rdy();
    while (!txrdy) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    wait_rdy();
    put(b, 1'b1);
  endtask

  task automatic drain();
    while (!(exp_q.size() == 0 && txe)) @(negedge clk);
    repeat (4 * TXC_P) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; sync_mode = 1'b0;
    factor_sel = 2'b10; parity_en = 1'b0; parity_odd = 1'b0; stop_sel = 2'b00;
    dual_sync = 1'b0; sync_a = 8'h4B; sync_b = 8'hD2; tx_en = 1'b0;
    send_break = 1'b0; cts_n = 1'b0;
    repeat (5) @(negedge clk);
    check(txd == 1'b1, "R1", "txd in reset", txd, 1);
    check(txrdy == 1'b0, "R1", "txrdy in reset", txrdy, 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check(txd == 1'b1, "R1", "txd after reset", txd, 1);
    check(txrdy == 1'b0, "R1", "txrdy while disabled", txrdy, 0);
    check(txe == 1'b1, "R1", "txe after reset", txe, 1);

    // R2: enable gating by command bit and clear-to-send
    tx_en = 1'b1; cts_n = 1'b1;
    repeat (5) @(negedge clk);
    check(txrdy == 1'b0, "R2", "txrdy with cts high", txrdy, 0);
    cts_n = 1'b0;
    repeat (5) @(negedge clk);
    check(txrdy == 1'b1, "R2", "txrdy when enabled", txrdy, 1);

    // R4 / R9: plain frames at x16
    mon_async = 1'b1;
    send(8'hA5);
    check(txe == 1'b0, "R9", "txe after write", txe, 0);
    check(txrdy == 1'b0, "R2", "txrdy after write", txrdy, 0);
    send(8'h3C);
    drain();
    check(txe == 1'b1, "R9", "txe after drain", txe, 1);
    check(txd == 1'b1, "R11", "mark after frames", txd, 1);

    // R5: parity even then odd
    parity_en = 1'b1; parity_odd = 1'b0;
    send(8'h5A);
    drain();
    parity_odd = 1'b1;
    send(8'h01);
    drain();
    parity_en = 1'b0; parity_odd = 1'b0;

    // R6: stop length measured between back-to-back starts
    stop_sel = 2'b01;
    starts.delete();
    send(8'hC3);
    send(8'h81);
    drain();
    check(starts.size() == 2, "R6", "frames with 1.5 stop", starts.size(), 2);
    if (starts.size() == 2)
      check(starts[1] - starts[0] == 9 * 256 + 24 * TXC_P, "R6", "gap 1.5 stop",
            starts[1] - starts[0], 9 * 256 + 24 * TXC_P);
    stop_sel = 2'b10;
    starts.delete();
    send(8'h18);
    send(8'hE7);
    drain();
    if (starts.size() == 2)
      check(starts[1] - starts[0] == 9 * 256 + 32 * TXC_P, "R6", "gap 2 stop",
            starts[1] - starts[0], 9 * 256 + 32 * TXC_P);
    else
      check(1'b0, "R6", "frames with 2 stop", starts.size(), 2);
    stop_sel = 2'b00;

    // R4: other factors
    factor_sel = 2'b11;
    send(8'h96);
    drain();
    factor_sel = 2'b01;
    send(8'h69);
    drain();
    factor_sel = 2'b10;

    // R12: write while full is dropped
    send(8'h11);
    wait_rdy();
    put(8'h22, 1'b1);
    check(txrdy == 1'b0, "R12", "txrdy while full", txrdy, 0);
    put(8'h33, 1'b0);
    drain();

    // R3: characters accepted before disable are finished
    send(8'h44);
    wait_rdy();
    put(8'h55, 1'b1);
    tx_en = 1'b0;
    repeat (3) @(negedge clk);
    put(8'h66, 1'b0);
    check(txrdy == 1'b0, "R2", "txrdy while disabled", txrdy, 0);
    drain();
    check(txe == 1'b1, "R3", "txe after disabled write", txe, 1);
    tx_en = 1'b1;
    repeat (12 * 256) @(negedge clk);
    check(exp_q.size() == 0 && txd == 1'b1, "R2", "discarded write stays unsent",
          exp_q.size(), 0);
    send(8'h77);
    cts_n = 1'b1;
    drain();
    check(txrdy == 1'b0, "R3", "txrdy after cts drop", txrdy, 0);
    cts_n = 1'b0;
    repeat (5) @(negedge clk);

    // R7: no progress without txc edges
    txc_run = 1'b0;
    starts.delete();
    send(8'h9C);
    repeat (600) @(negedge clk);
    check(txd == 1'b1 && starts.size() == 0, "R7", "line held with txc stopped",
          txd, 1);
    txc_run = 1'b1;
    drain();
    check(starts.size() == 1, "R7", "frame after txc resumes", starts.size(), 1);

    // R10: break overrides the line
    mon_async = 1'b0;
    send_break = 1'b1;
    repeat (2) @(negedge clk);
    check(txd == 1'b0, "R10", "break low", txd, 0);
    repeat (300) @(negedge clk);
    check(txd == 1'b0, "R10", "break held", txd, 0);
    send_break = 1'b0;
    repeat (2) @(negedge clk);
    check(txd == 1'b1, "R11", "mark after break", txd, 1);

    // R8: synchronous fill
    sync_mode = 1'b1; dual_sync = 1'b1;
    sbits.delete();
    mon_sync = 1'b1;
    repeat (40 * TXC_P) @(negedge clk);
    check(txe == 1'b1, "R9", "txe during fill", txe, 1);
    send(8'h5E);
    check(txe == 1'b0, "R9", "txe after sync write", txe, 0);
    repeat (60 * TXC_P) @(negedge clk);
    check(has_seq(8'h4B, 8'hD2, 8'h4B), "R8", "dual fill order", 0, 1);
    check(has_seq(8'h5E, 8'h4B, 8'hD2), "R8", "data then fill restart", 0, 1);
    dual_sync = 1'b0;
    sbits.delete();
    send(8'h77);
    repeat (60 * TXC_P) @(negedge clk);
    check(has_seq(8'h77, 8'h4B, 8'h4B), "R8", "single fill repeat", 0, 1);
    tx_en = 1'b0;
    repeat (30 * TXC_P) @(negedge clk);
    check(txd == 1'b1, "R11", "mark after sync disable", txd, 1);
    check(txe == 1'b1, "R9", "txe after sync disable", txe, 1);
    mon_sync = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule